// File: doc/BRIEF.md
# Multi-Word Serial Debug Transmitter

This block takes a fixed set of 8-bit result words and sends them one after another on a single asynchronous serial line, so that a host on the far end can receive them and check them bit by bit. The caller supplies a strobe that pulses once per bit period. A slot counter moves forward only on that strobe, and the slot it holds decides what the line carries. Each word goes out as one framed character: a start bit, eight data bits sent least significant bit first, and a stop bit. The characters follow one another with no gap, in word-index order. After the last stop bit the line rests high until the counter wraps and the next pass begins.

The counter's wrap point is a parameter and is set well past the end of the frames. The slots between the last stop bit and the wrap therefore form an idle gap, which gives the receiver time to resynchronise between bursts. At the strobe that starts a pass, the block captures all words into a shadow register. Changes on the input words after that point do not alter the pass in progress. A busy output marks the slots that belong to a frame.

Top module: `dbg_frame_tx`

## Requirements
- R1: While rst_ni is low, tx_o is 1 and busy_o is 0, whatever the other inputs do. This takes effect at once, in the middle of a pass as well.
- R2: The slot position changes only on a clock edge where bit_en_i is 1. With bit_en_i held at 0, tx_o and busy_o keep their values.
- R3: Each word takes 10 consecutive slots. The start slot drives tx_o to 0, the next eight carry data bits 0 to 7 in that order (least significant bit first), and the stop slot drives tx_o to 1.
- R4: Words go out back to back in index order. Word k is words_i[8k+7:8k], so word 0 (the low byte) is sent first, and the stop slot of word k is followed directly by the start slot of word k+1.
- R5: All of words_i is captured at the strobe that moves the counter into slot 0. Changes to words_i after that strobe do not affect the pass in progress.
- R6: busy_o is 1 exactly during the NUM_WORDS*10 frame slots of a pass. Whenever busy_o is 0, tx_o is 1.
- R7: After the stop slot of the last word, the line stays idle for SLOT_LIMIT+1-NUM_WORDS*10 slots. The counter then wraps from SLOT_LIMIT to 0 and a new pass begins.
- R8: Reset leaves the counter on its last slot (SLOT_LIMIT). The line therefore idles after reset until the first strobe, and that strobe starts a pass at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-period strobe; advances the slot counter by one |
| words_i | input | NUM_WORDS*8 | Words to send; word k in bits [8k+7:8k] |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | High while the current slot belongs to a frame |

## Verification
The bench drives one strobe every other clock and decodes every slot of five passes. The word patterns include all zeros, all ones and alternating bits. A design that swapped the bit order, dropped a stop bit or sent the words in the wrong order would show a wrong level in a specific slot. After each capture the bench inverts words_i, so a design that read the live inputs instead of the shadow copy would send the inverted data. The bench also holds the strobe low in the middle of a data bit, counts the exact length of the idle gap, and applies reset in the middle of a pass. A design that started a pass straight out of reset, shortened the gap by one slot, or kept state across reset would shift the line by a slot or fail to show the start bit at the first strobe.

// File: rtl/dbg_tx_pkg.sv
package dbg_tx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned BIT_W   = $clog2(DATA_W);
  localparam int unsigned FRAME_W = DATA_W + 2;  // start + data + stop

  typedef enum logic [1:0] {
    ROLE_IDLE  = 2'd0,
    ROLE_START = 2'd1,
    ROLE_DATA  = 2'd2,
    ROLE_STOP  = 2'd3
  } slot_role_e;
endpackage

// File: rtl/dbg_slot_seq.sv
module dbg_slot_seq
  import dbg_tx_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 4,
  parameter int unsigned SLOT_LIMIT = 59,
  parameter int unsigned WIDX_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  output slot_role_e        role_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              load_o
);
  localparam int unsigned CNT_W = $clog2(SLOT_LIMIT + 1);
  localparam logic [CNT_W-1:0]  LIMIT_C  = CNT_W'(SLOT_LIMIT);
  localparam logic [WIDX_W-1:0] LAST_W   = WIDX_W'(NUM_WORDS - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  slot_role_e        role_q;
  logic [WIDX_W-1:0] widx_q;
  logic [BIT_W-1:0]  bit_q;
  logic              at_limit;

  assign at_limit = (cnt_q == LIMIT_C);
  assign load_o   = bit_en_i & at_limit;

  // reset parks the counter on its last slot so the line idles until a strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LIMIT_C;
      role_q <= ROLE_IDLE;
      widx_q <= '0;
      bit_q  <= '0;
    end else if (bit_en_i) begin
      if (at_limit) begin
        cnt_q  <= '0;
        role_q <= ROLE_START;
        widx_q <= '0;
        bit_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        case (role_q)
          ROLE_START: begin
            role_q <= ROLE_DATA;
            bit_q  <= '0;
          end
          ROLE_DATA: begin
            if (bit_q == LAST_BIT) role_q <= ROLE_STOP;
            else                   bit_q  <= bit_q + BIT_W'(1);
          end
          ROLE_STOP: begin
            if (widx_q == LAST_W) begin
              role_q <= ROLE_IDLE;
            end else begin
              role_q <= ROLE_START;
              widx_q <= widx_q + WIDX_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign role_o = role_q;
  assign widx_o = widx_q;
  assign bit_o  = bit_q;
endmodule

// File: rtl/dbg_word_hold.sv
module dbg_word_hold
  import dbg_tx_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [NUM_WORDS*DATA_W-1:0] words_i,
  output logic [NUM_WORDS*DATA_W-1:0] words_o
);
  logic [NUM_WORDS*DATA_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (load_i) shadow_q <= words_i;
  end

  assign words_o = shadow_q;
endmodule

// File: rtl/dbg_bit_sel.sv
module dbg_bit_sel
  import dbg_tx_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WIDX_W    = 2
) (
  input  slot_role_e                  role_i,
  input  logic [WIDX_W-1:0]           widx_i,
  input  logic [BIT_W-1:0]            bit_i,
  input  logic [NUM_WORDS*DATA_W-1:0] words_i,
  output logic                        tx_o,
  output logic                        busy_o
);
  logic [DATA_W-1:0] word_arr [NUM_WORDS];
  logic [DATA_W-1:0] word_sel;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_split
    assign word_arr[k] = words_i[k*DATA_W +: DATA_W];
  end

  assign word_sel = word_arr[widx_i];

  always_comb begin
    case (role_i)
      ROLE_START: tx_o = 1'b0;
      ROLE_DATA:  tx_o = word_sel[bit_i];
      default:    tx_o = 1'b1;
    endcase
  end

  assign busy_o = (role_i != ROLE_IDLE);
endmodule

// File: rtl/dbg_frame_tx.sv
module dbg_frame_tx
  import dbg_tx_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 4,
  parameter int unsigned SLOT_LIMIT = 59
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bit_en_i,
  input  logic [NUM_WORDS*DATA_W-1:0] words_i,
  output logic                        tx_o,
  output logic                        busy_o
);
  localparam int unsigned WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  slot_role_e                  role;
  logic [WIDX_W-1:0]           widx;
  logic [BIT_W-1:0]            bit_idx;
  logic                        load;
  logic [NUM_WORDS*DATA_W-1:0] held;

  dbg_slot_seq #(
    .NUM_WORDS (NUM_WORDS),
    .SLOT_LIMIT(SLOT_LIMIT),
    .WIDX_W    (WIDX_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_en_i(bit_en_i),
    .role_o  (role),
    .widx_o  (widx),
    .bit_o   (bit_idx),
    .load_o  (load)
  );

  dbg_word_hold #(
    .NUM_WORDS(NUM_WORDS)
  ) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .words_i(words_i),
    .words_o(held)
  );

  dbg_bit_sel #(
    .NUM_WORDS(NUM_WORDS),
    .WIDX_W   (WIDX_W)
  ) u_sel (
    .role_i (role),
    .widx_i (widx),
    .bit_i  (bit_idx),
    .words_i(held),
    .tx_o   (tx_o),
    .busy_o (busy_o)
  );
endmodule

// File: rtl/dbg_frame_tx_chk.sv
module dbg_frame_tx_chk #(
  parameter int unsigned NUM_WORDS  = 4,
  parameter int unsigned SLOT_LIMIT = 59
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic tx_o,
  input logic busy_o
);
  localparam int unsigned FRAME = NUM_WORDS * dbg_tx_pkg::FRAME_W;
  localparam int unsigned GAP   = SLOT_LIMIT + 1 - FRAME;
  localparam int unsigned CW    = $clog2(SLOT_LIMIT + 2);

  logic [CW-1:0] busy_len_q;
  logic [CW-1:0] gap_q;
  logic          busy_d_q;
  logic          seen_fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_len_q  <= '0;
      gap_q       <= '0;
      busy_d_q    <= 1'b0;
      seen_fall_q <= 1'b0;
    end else begin
      busy_d_q    <= busy_o;
      seen_fall_q <= seen_fall_q | (busy_d_q & ~busy_o);
      if (!busy_o)       busy_len_q <= '0;
      else if (bit_en_i) busy_len_q <= busy_len_q + CW'(1);
      if (busy_o)        gap_q <= '0;
      else if (bit_en_i) gap_q <= gap_q + CW'(1);
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (tx_o && !busy_o));

  a_r2_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(tx_o) && $stable(busy_o)));

  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tx_o);

  a_r6_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  a_r6_frame_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len_q == CW'(FRAME)));

  a_r7_gap_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && seen_fall_q) |-> (gap_q == CW'(GAP)));
endmodule

bind dbg_frame_tx dbg_frame_tx_chk #(
  .NUM_WORDS (NUM_WORDS),
  .SLOT_LIMIT(SLOT_LIMIT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .bit_en_i(bit_en_i),
  .tx_o    (tx_o),
  .busy_o  (busy_o)
);

// File: tb/dbg_frame_tx_bench.sv
`timescale 1ns/1ps
module dbg_frame_tx_bench;
  localparam int NW  = 4;
  localparam int LIM = 59;
  localparam int FR  = NW * 10;
  localparam int GAP = LIM + 1 - FR;
  localparam int NP  = 5;
  localparam logic [NW*8-1:0] PAT [NP] = '{
    32'hA53C_0F81, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0180_7E55, 32'hC396_24E7
  };

  logic            clk = 1'b0;
  logic            rst_ni;
  logic            bit_en;
  logic [NW*8-1:0] words;
  logic            tx, busy;
  int              n_chk = 0;
  int              n_bad = 0;
  bit              done = 0;

  always #2.5 clk = ~clk;

  dbg_frame_tx #(.NUM_WORDS(NW), .SLOT_LIMIT(LIM)) u_dbg_frame_tx (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en),
    .words_i(words), .tx_o(tx), .busy_o(busy)
  );

  task automatic check(input string req, input logic exp_tx, input logic exp_busy);
    n_chk++;
    if (tx !== exp_tx || busy !== exp_busy) begin
      n_bad++;
      $display("FAIL %s: tx=%0b exp %0b, busy=%0b exp %0b", req, tx, exp_tx, busy, exp_busy);
    end
  endtask

  // one strobe; returns at a falling edge after the capturing rising edge
  task automatic strobe();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
  endtask

  task automatic run_pass(input logic [NW*8-1:0] w, input bit stall);
    logic exp;
    words = w;
    strobe();
    check("R8/R4 pass start", 1'b0, 1'b1);
    words = ~w;  // R5: must not reach the line this pass
    for (int wi = 0; wi < NW; wi++) begin
      for (int s = 0; s < 10; s++) begin
        if (wi != 0 || s != 0) strobe();
        if (s == 0)      exp = 1'b0;
        else if (s == 9) exp = 1'b1;
        else             exp = w[wi*8 + s - 1];
        check((s == 0 || s == 9) ? "R3 frame" : "R4/R5 data", exp, 1'b1);
        if (stall && s == 4) begin
          repeat (6) @(negedge clk);
          check("R2 stall", exp, 1'b1);
        end
      end
    end
    for (int g = 0; g < GAP; g++) begin
      strobe();
      check("R7/R6 gap", 1'b1, 1'b0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    bit_en = 1'b0;
    words  = PAT[0];
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b1, 1'b0);
    bit_en = 1'b1;
    @(negedge clk);
    check("R1 reset with strobe", 1'b1, 1'b0);
    bit_en = 1'b0;
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 idle before strobe", 1'b1, 1'b0);

    for (int p = 0; p < NP; p++) run_pass(PAT[p], p == 1);

    // reset in mid pass
    words = PAT[3];
    strobe();
    strobe();
    check("R3 first data bit", PAT[3][0], 1'b1);
    @(negedge clk) rst_ni = 1'b0;
    #1;
    check("R1 async reset mid pass", 1'b1, 1'b0);
    @(negedge clk) rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 idle after reset", 1'b1, 1'b0);
    run_pass(PAT[4], 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule